// File: doc/BRIEF.md
# I2C Master Bit Timing Engine

This block produces the bus-level waveforms of an I2C master, one bit-level operation at a time. A byte-level controller hands it one command at a time over a valid/ready handshake. The four commands are start, stop, write one bit, and read one bit. The block drives the open-drain clock and data lines through release/pull-low outputs. When the operation finishes, it returns a one-cycle done strobe. Bit commands also return the sampled data bit with that strobe.

All phase durations come from one programmable SCL period, counted in system clock cycles. With H standing for half of that period, the phases are timed as follows:
- Both SCL levels last H.
- The bus-free gap and the start hold last H-1.
- The repeated-start setup lasts 2H.
- The stop setup lasts H+2.
- Data changes three cycles after the SCL low phase begins.

The SCL high phase is counted only from the moment the bus is seen high. A slave that holds SCL low therefore stretches the clock. The delay of the input synchronizer is subtracted from the count, so the observed high time is still exactly H.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is asserted, and after it is released, `scl_o` and `sda_o` are both 1 (line released), `cmd_ready_o` is 1 and `done_o` is 0.
- R2: A start command (`cmd_op_i` = 0) accepted while the bus is free does the following:
  - it pulls SDA low H-1 cycles after acceptance;
  - it pulls SCL low H-1 cycles after that;
  - it raises `done_o` in the same cycle that SCL goes low.
- R3: A bit command, write (`cmd_op_i` = 2) or read (`cmd_op_i` = 3), accepted while the block owns the bus does the following:
  - it updates SDA 3 cycles after acceptance, which is at least 3 cycles after SCL fell;
  - it releases SCL H cycles after acceptance.
- R4: In a bit command, SCL stays high for exactly H cycles, measured from the cycle the bus is first seen high. SCL is then pulled low, and `done_o` pulses in that same cycle. SDA does not change while SCL is high during a bit command.
- R5: While a slave holds SCL low after the master releases it, the high phase does not start. Its H-cycle count begins only when the line is seen high.
- R6: A write puts `cmd_bit_i` on SDA (1 = release, 0 = pull low). A read releases SDA and samples the bus SDA during the SCL high phase. Both return the sampled level on `rd_bit_o` in the cycle `done_o` pulses.
- R7: A stop command (`cmd_op_i` = 1) proceeds as follows:
  - it pulls SDA low 3 cycles after acceptance;
  - it releases SCL H cycles after acceptance;
  - it releases SDA H+2 cycles after SCL is seen high, with `done_o` in that cycle;
  - it then returns the block to the free state.
- R8: A start command accepted while the block owns the bus is a repeated start. It proceeds as follows:
  - it releases SDA after 3 cycles and SCL after H cycles;
  - it pulls SDA low 2H cycles after SCL is seen high;
  - it pulls SCL low H-1 cycles after that, with `done_o` in that cycle.
- R9: The SCL period is taken from `period_i` through a register. An odd value is rounded down to even, and a value below 16 is replaced by 16. H is half the result, latched when each command is accepted.
- R10: A stop, write or read command accepted while the bus is free leaves both lines untouched. It is answered with `done_o` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | DIV_W | SCL period in system clock cycles |
| cmd_valid_i | input | 1 | Command offered |
| cmd_op_i | input | 2 | 0 start, 1 stop, 2 write bit, 3 read bit |
| cmd_bit_i | input | 1 | Bit value for a write |
| cmd_ready_o | output | 1 | Block can take a command |
| done_o | output | 1 | One-cycle completion strobe |
| rd_bit_o | output | 1 | SDA level sampled by the last bit command |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive: 0 pulls low, 1 releases |

## Verification
The bench uses the default parameters:
- a 12-bit divider;
- a two-stage synchronizer, which gives a three-cycle rise latency;
- a 3-cycle data hold and a minimum period of 16.

It changes `period_i` at run time between 24, 10 and 41. The value 10 is clamped to 16, giving H = 8. This is the shortest high count (5 cycles), where the synchronizer compensation and the read sample point leave the least margin. The value 41 is rounded down to 40, which exercises the even rounding and a long H of 20. Every edge on both bus lines and every done strobe is compared against a cycle-exact expectation. This includes a stretch of 7 cycles.

// File: rtl/i2c_bt_pkg.sv
// Shared command and sequencer state encodings for the I2C bit timing engine.
package i2c_bt_pkg;

    // Command codes seen on cmd_op_i; values are part of the block's interface.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bt_op_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_IDLE,    // bus free, both lines released
        ST_OWNED,   // master owns bus, SCL held low between commands
        ST_FREE,    // bus-free guard before a fresh start
        ST_LHOLD,   // SCL low, SDA held from previous bit
        ST_LSETUP,  // SCL low, new SDA value set up
        ST_RISE,    // SCL released, waiting to see it high
        ST_HIGH,    // SCL high phase being counted
        ST_SHOLD    // start hold: SDA low, SCL still high
    } bt_state_e;

endpackage

// File: rtl/i2c_bt_sync.sv
// Multi-stage synchronizer for an asynchronous bus line.
// Assumes the line idles high, so every stage resets to 1.
module i2c_bt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] ff;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) ff[g] <= 1'b1;
                else        ff[g] <= d_i;
            end
        end else begin : g_next
            // Later stages settle the captured value.
            always_ff @(posedge clk) begin
                if (!rst_n) ff[g] <= 1'b1;
                else        ff[g] <= ff[g-1];
            end
        end
    end

    assign q_o = ff[STAGES-1];

endmodule

// File: rtl/i2c_bt_divider.sv
// Registers the requested SCL period and produces its half.
// The period is forced even by dropping bit 0. Values below MIN_PERIOD are replaced by MIN_PERIOD.
// Assumes MIN_PERIOD is even and fits in DIV_W bits.
module i2c_bt_divider #(
    parameter int DIV_W      = 12,
    parameter int MIN_PERIOD = 16,
    localparam int HW        = DIV_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] period_i,
    output logic [HW-1:0]    half_o
);

    logic          too_small;
    logic [HW-1:0] half_n;

    // Clamp to the minimum, otherwise halve (this discards an odd LSB).
    always_comb begin
        too_small = (period_i < DIV_W'(MIN_PERIOD));
        half_n    = too_small ? HW'(MIN_PERIOD / 2) : period_i[DIV_W-1:1];
    end

    // Hold the legal half period for the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) half_o <= HW'(MIN_PERIOD / 2);
        else        half_o <= half_n;
    end

    // R9: the registered half period is never below the minimum.
    a_r9_half_floor: assert property (@(posedge clk) disable iff (!rst_n)
        half_o >= HW'(MIN_PERIOD / 2));

endmodule

// File: rtl/i2c_bt_phase_len.sv
// Computes the length, in system clock cycles, of the phase the sequencer is in.
// It also computes the high-phase cycle index at which SDA is sampled.
// Every length is derived from the latched half period h.
// Assumes h exceeds both HOLD_CYC and RISE_LAT.
module i2c_bt_phase_len
    import i2c_bt_pkg::*;
#(
    parameter int HW         = 11,
    parameter int HOLD_CYC   = 3,
    parameter int BUF_TRIM   = 1,
    parameter int STOP_EXTRA = 2,
    parameter int RISE_LAT   = 3,
    localparam int CW        = HW + 2
) (
    input  bt_state_e      state_i,
    input  bt_op_e         op_i,
    input  logic [HW-1:0]  half_i,
    output logic [CW-1:0]  len_o,
    output logic [CW-1:0]  samp_o
);

    logic [CW-1:0] h;

    // Pick the phase length from the current state and command.
    always_comb begin
        h = CW'(half_i);
        unique case (state_i)
            ST_FREE, ST_SHOLD: len_o = h - CW'(BUF_TRIM);
            ST_LHOLD:          len_o = CW'(HOLD_CYC);
            ST_LSETUP:         len_o = h - CW'(HOLD_CYC);
            ST_HIGH: begin
                unique case (op_i)
                    OP_STOP:  len_o = h + CW'(STOP_EXTRA) - CW'(RISE_LAT);
                    OP_START: len_o = (h << 1) - CW'(RISE_LAT);
                    default:  len_o = h - CW'(RISE_LAT);
                endcase
            end
            default:           len_o = CW'(1);
        endcase
    end

    // Sample SDA near the bus midpoint of the high phase, allowing for synchronizer lag.
    always_comb samp_o = (h >> 1) - CW'(RISE_LAT) + CW'(1);

endmodule

// File: rtl/i2c_bt_seq.sv
// Bit-level sequencer. It accepts one command at a time and walks the SCL/SDA phases.
// It strobes done when the operation completes.
// Assumes scl_s_i and sda_s_i are synchronized bus levels that lag the bus by RISE_LAT-1 cycles.
module i2c_bt_seq
    import i2c_bt_pkg::*;
#(
    parameter int HW         = 11,
    parameter int HOLD_CYC   = 3,
    parameter int BUF_TRIM   = 1,
    parameter int STOP_EXTRA = 2,
    parameter int RISE_LAT   = 3,
    parameter int MIN_HALF   = 8,
    localparam int CW        = HW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid_i,
    input  bt_op_e        cmd_op_i,
    input  logic          cmd_bit_i,
    input  logic [HW-1:0] half_i,
    input  logic          scl_s_i,
    input  logic          sda_s_i,
    output logic          cmd_ready_o,
    output logic          done_o,
    output logic          rd_bit_o,
    output logic          scl_o,
    output logic          sda_o
);

    bt_state_e     st_q;
    bt_op_e        op_q;
    logic          bit_q;
    logic          samp_q;
    logic [HW-1:0] h_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len;
    logic [CW-1:0] samp_at;
    logic          last;
    logic          accept;
    logic          is_bit;

    i2c_bt_phase_len #(
        .HW(HW), .HOLD_CYC(HOLD_CYC), .BUF_TRIM(BUF_TRIM),
        .STOP_EXTRA(STOP_EXTRA), .RISE_LAT(RISE_LAT)
    ) u_len (
        .state_i(st_q), .op_i(op_q), .half_i(h_q), .len_o(len), .samp_o(samp_at)
    );

    // Handshake and phase-end decode.
    always_comb begin
        cmd_ready_o = (st_q == ST_IDLE) || (st_q == ST_OWNED);
        accept      = cmd_valid_i && cmd_ready_o;
        last        = (cnt_q == len - CW'(1));
        is_bit      = (op_q == OP_WRITE) || (op_q == OP_READ);
    end

    // Phase sequencing and line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            op_q     <= OP_START;
            bit_q    <= 1'b1;
            samp_q   <= 1'b1;
            h_q      <= HW'(MIN_HALF);
            cnt_q    <= '0;
            done_o   <= 1'b0;
            rd_bit_o <= 1'b1;
            scl_o    <= 1'b1;
            sda_o    <= 1'b1;
        end else begin
            done_o <= 1'b0;
            cnt_q  <= cnt_q + CW'(1);
            unique case (st_q)
                ST_IDLE: if (accept) begin
                    cnt_q <= '0;
                    op_q  <= cmd_op_i;
                    bit_q <= cmd_bit_i;
                    h_q   <= half_i;
                    if (cmd_op_i == OP_START) st_q <= ST_FREE;
                    else                      done_o <= 1'b1;
                end
                ST_OWNED: if (accept) begin
                    cnt_q <= '0;
                    op_q  <= cmd_op_i;
                    bit_q <= cmd_bit_i;
                    h_q   <= half_i;
                    st_q  <= ST_LHOLD;
                end
                ST_FREE: if (last) begin
                    cnt_q <= '0;
                    sda_o <= 1'b0;
                    st_q  <= ST_SHOLD;
                end
                ST_LHOLD: if (last) begin
                    cnt_q <= '0;
                    unique case (op_q)
                        OP_WRITE: sda_o <= bit_q;
                        OP_STOP:  sda_o <= 1'b0;
                        default:  sda_o <= 1'b1;
                    endcase
                    st_q <= ST_LSETUP;
                end
                ST_LSETUP: if (last) begin
                    cnt_q <= '0;
                    scl_o <= 1'b1;
                    st_q  <= ST_RISE;
                end
                ST_RISE: if (scl_s_i) begin
                    cnt_q <= '0;
                    st_q  <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (cnt_q == samp_at) samp_q <= sda_s_i;
                    if (last) begin
                        cnt_q <= '0;
                        unique case (op_q)
                            OP_STOP: begin
                                sda_o  <= 1'b1;
                                done_o <= 1'b1;
                                st_q   <= ST_IDLE;
                            end
                            OP_START: begin
                                sda_o <= 1'b0;
                                st_q  <= ST_SHOLD;
                            end
                            default: begin
                                scl_o    <= 1'b0;
                                done_o   <= 1'b1;
                                rd_bit_o <= samp_q;
                                st_q     <= ST_OWNED;
                            end
                        endcase
                    end
                end
                ST_SHOLD: if (last) begin
                    cnt_q  <= '0;
                    scl_o  <= 1'b0;
                    done_o <= 1'b1;
                    st_q   <= ST_OWNED;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R1 / R10: a free bus has both lines released.
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (scl_o && sda_o));

    // R3: between commands the owning master holds SCL low.
    a_r3_owned_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OWNED) |-> !scl_o);

    // R5: no high-phase counting while the bus still shows SCL low.
    a_r5_wait_for_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RISE && !scl_s_i) |=> (st_q == ST_RISE));

    // R4: SDA is steady through the high phase of a bit.
    a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && $past(st_q) == ST_HIGH && is_bit) |-> $stable(sda_o));

    // R4: a bit completes together with the SCL fall.
    a_r4_done_with_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && last && is_bit) |=> (done_o && !scl_o));

    // R7: after a stop completes, the bus is free with SDA released.
    a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && last && op_q == OP_STOP) |=> (sda_o && st_q == ST_IDLE));

endmodule

// File: rtl/i2c_bit_timer.sv
// Top level of the I2C master bit timing engine.
// It synchronizes the bus lines, registers the period, and runs the command sequencer.
// Assumes MIN_PERIOD/2 is larger than HOLD_CYC and than SYNC_STAGES+1.
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int MIN_PERIOD  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3,
    parameter int BUF_TRIM    = 1,
    parameter int STOP_EXTRA  = 2,
    localparam int HW         = DIV_W - 1,
    localparam int RISE_LAT   = SYNC_STAGES + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] period_i,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_op_i,
    input  logic             cmd_bit_i,
    output logic             cmd_ready_o,
    output logic             done_o,
    output logic             rd_bit_o,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_o,
    output logic             sda_o
);

    logic          scl_s;
    logic          sda_s;
    logic [HW-1:0] half;

    i2c_bt_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );

    i2c_bt_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    i2c_bt_divider #(.DIV_W(DIV_W), .MIN_PERIOD(MIN_PERIOD)) u_div (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .half_o(half)
    );

    i2c_bt_seq #(
        .HW(HW), .HOLD_CYC(HOLD_CYC), .BUF_TRIM(BUF_TRIM),
        .STOP_EXTRA(STOP_EXTRA), .RISE_LAT(RISE_LAT), .MIN_HALF(MIN_PERIOD / 2)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(bt_op_e'(cmd_op_i)), .cmd_bit_i(cmd_bit_i),
        .half_i(half), .scl_s_i(scl_s), .sda_s_i(sda_s),
        .cmd_ready_o(cmd_ready_o), .done_o(done_o), .rd_bit_o(rd_bit_o),
        .scl_o(scl_o), .sda_o(sda_o)
    );

endmodule

// File: tb/i2c_bit_timer_tb_top.sv
`timescale 1ns/1ps
module i2c_bit_timer_tb_top;

    localparam int DIV_W = 12;
    localparam int K_SCL = 0, K_SDA = 1, K_DONE = 2;
    localparam int C_START = 0, C_STOP = 1, C_WRITE = 2, C_READ = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [DIV_W-1:0] period_i = 24;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic cmd_bit = 1'b0;
    logic cmd_ready, done, rd_bit, scl_o, sda_o;
    logic scl_hold = 1'b0;
    logic slave_sda = 1'b1;
    wire scl_line = scl_o & ~scl_hold;
    wire sda_line = sda_o & slave_sda;

    i2c_bit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .period_i(period_i),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_bit_i(cmd_bit),
        .cmd_ready_o(cmd_ready), .done_o(done), .rd_bit_o(rd_bit),
        .scl_i(scl_line), .sda_i(sda_line), .scl_o(scl_o), .sda_o(sda_o)
    );

    typedef struct {
        int    kind;
        int    at;
        int    val;
        string req;
    } ev_t;

    ev_t   q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    half = 12;
    bit    owned = 1'b0;
    bit    ms = 1'b1;
    bit    ss = 1'b1;
    string tag_over = "";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int half_of(input int p);
        int e;
        e = (p < 16) ? 16 : (p & ~1);
        return e / 2;
    endfunction

    function automatic void push(input int kind, input int at, input int val, input string req);
        ev_t e;
        e.kind = kind; e.at = at; e.val = val;
        e.req  = (tag_over != "") ? tag_over : req;
        q.push_back(e);
    endfunction

    function automatic void sda_set(input int at, input bit v, input string req);
        bit old;
        old = ms & ss;
        ms  = v;
        if ((ms & ss) != old) push(K_SDA, at, ms & ss, req);
    endfunction

    function automatic void observe(input int kind, input int val);
        ev_t e;
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL unexpected event kind=%0d val=%0d at %0d: actual=event expected=none (R10)",
                     kind, val, cyc);
            return;
        end
        e = q.pop_front();
        if (e.kind != kind || e.at != cyc || (e.val >= 0 && e.val != val)) begin
            errors++;
            $display("FAIL %s: actual kind=%0d cyc=%0d val=%0d expected kind=%0d cyc=%0d val=%0d",
                     e.req, kind, cyc, val, e.kind, e.at, e.val);
        end
    endfunction

    // Monitor: report every bus edge and every done strobe to the scoreboard.
    logic pscl = 1'b1, psda = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line !== pscl) observe(K_SCL, int'(scl_line));
            if (sda_line !== psda) observe(K_SDA, int'(sda_line));
            if (done) observe(K_DONE, int'(rd_bit));
            pscl = scl_line;
            psda = sda_line;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_slave(input bit v);
        bit old;
        @(posedge clk); #1;
        old = ms & ss;
        ss = v;
        slave_sda = v;
        if ((ms & ss) != old) push(K_SDA, cyc, ms & ss, "R6");
    endtask

    // Driver: offer one command, push its expected bus events, wait for completion.
    task automatic issue(input int op, input bit b, input int s);
        int a, h, r, t_end;
        h = half;
        if (s > 0) scl_hold = 1'b1;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_bit = b;
        a = cyc + 1;
        if (!owned) begin
            if (op == C_START) begin
                sda_set(a + h - 1, 1'b0, "R2");
                push(K_SCL, a + 2*h - 2, 0, "R2");
                push(K_DONE, a + 2*h - 2, -1, "R2");
                t_end = a + 2*h - 2;
                owned = 1'b1;
            end else begin
                push(K_DONE, a, -1, "R10");
                t_end = a;
            end
        end else begin
            r = a + h + s;
            case (op)
                C_WRITE, C_READ: begin
                    sda_set(a + 3, (op == C_WRITE) ? b : 1'b1, "R3");
                    push(K_SCL, r, 1, (s > 0) ? "R5" : "R3");
                    push(K_SCL, r + h, 0, (s > 0) ? "R5" : "R4");
                    push(K_DONE, r + h, int'(ms & ss), "R6");
                    t_end = r + h;
                end
                C_STOP: begin
                    sda_set(a + 3, 1'b0, "R7");
                    push(K_SCL, r, 1, "R7");
                    sda_set(r + h + 2, 1'b1, "R7");
                    push(K_DONE, r + h + 2, -1, "R7");
                    t_end = r + h + 2;
                    owned = 1'b0;
                end
                default: begin
                    sda_set(a + 3, 1'b1, "R8");
                    push(K_SCL, r, 1, "R8");
                    sda_set(r + 2*h, 1'b0, "R8");
                    push(K_SCL, r + 3*h - 1, 0, "R8");
                    push(K_DONE, r + 3*h - 1, -1, "R8");
                    t_end = r + 3*h - 1;
                end
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        if (s > 0) begin
            while (cyc < a + h + s) begin
                @(posedge clk); #1;
            end
            scl_hold = 1'b0;
        end
        while (cyc < t_end) @(negedge clk);
    endtask

    task automatic new_period(input int p);
        @(negedge clk);
        period_i = DIV_W'(p);
        half = half_of(p);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: lines released and handshake idle during reset.
        check(scl_o && sda_o, "R1", int'({scl_o, sda_o}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset release.
        check(scl_line && sda_line, "R1", int'({scl_line, sda_line}), 3);
        check(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);
        check(done == 1'b0, "R1", int'(done), 0);
        repeat (3) @(negedge clk);

        // R10: a write on a free bus is answered without any line change.
        issue(C_WRITE, 1'b0, 0);
        repeat (3) @(negedge clk);
        // R2: fresh start with H = 12.
        issue(C_START, 1'b0, 0);
        // R3, R4, R6: data bits.
        issue(C_WRITE, 1'b1, 0);
        issue(C_WRITE, 1'b0, 0);
        // R5: slave stretches SCL by 7 cycles.
        issue(C_WRITE, 1'b1, 7);
        // R6: reads with the slave driving 0 and then releasing.
        set_slave(1'b0);
        issue(C_READ, 1'b0, 0);
        set_slave(1'b1);
        issue(C_READ, 1'b0, 0);
        // R8: repeated start, then a bit and a stop (R7).
        issue(C_START, 1'b0, 0);
        issue(C_WRITE, 1'b0, 0);
        issue(C_STOP, 1'b0, 0);

        // R9: period 10 is clamped to 16.
        tag_over = "R9";
        new_period(10);
        issue(C_START, 1'b0, 0);
        issue(C_WRITE, 1'b0, 0);
        set_slave(1'b0);
        issue(C_READ, 1'b0, 0);
        set_slave(1'b1);
        issue(C_STOP, 1'b0, 0);
        // R9: odd period 41 is rounded to 40.
        new_period(41);
        issue(C_START, 1'b0, 0);
        issue(C_READ, 1'b0, 0);
        issue(C_STOP, 1'b0, 0);
        tag_over = "";

        repeat (20) @(negedge clk);
        // R7: bus left free and no expected event outstanding.
        check(q.size() == 0, "R7", q.size(), 0);
        check(scl_line && sda_line && cmd_ready, "R7",
              int'({scl_line, sda_line, cmd_ready}), 7);
        finish_run();
    end

endmodule